// File: doc/BRIEF.md
# Timer-Stamping Input Capture Channel

This block watches one external input pin and, each time a selected edge pattern is seen, stores a copy of one of two free-running timer values in a four-entry first-in first-out buffer. Software picks the edge kind through a three-bit mode field. The choices are both edges, falling only, rising only, every fourth rising edge or every sixteenth rising edge. The field also has an off setting, a disabled setting and a wake-pin setting. A read strobe removes the oldest stored value.

An interrupt pulse is raised after a programmed number of stored captures. When the channel is in the both-edges mode, the pulse comes on every capture instead. In the wake-pin mode nothing is stored. A rising edge on the pin raises the interrupt, but only while the sleep or idle input is high. An idle-stop bit freezes capturing while the idle input is high. The pin is synchronised with two flops before edge detection.

Top module: `capture_channel`

## Requirements
- R1: After reset `ctl_rdata` is 0. A control write stores bit 13 (idle stop), bit 7 (timer select), bits 6:5 (interrupt count) and bits 2:0 (mode), and reading returns them at those positions. Bits 15:14 and 12:8 always read 0.
- R2: A pin change driven between clock edges is stored on the third rising clock edge after it. The timer value sampled is the one present just before that edge.
- R3: The buffer holds 4 values. A capture that arrives while the buffer is full and no value is popped in the same cycle is discarded and sets the overflow flag (bit 4). The flag stays set while the mode is not 000. Stored values are kept.
- R4: Mode 001 captures on both rising and falling edges. It raises one interrupt per stored capture whatever the interrupt-count field holds.
- R5: Mode 010 captures only falling edges. Mode 011 captures only rising edges.
- R6: Mode 100 captures on every 4th rising edge. Mode 101 captures on every 16th rising edge.
- R7: With timer select = 1 the stored value is `timer_a`. With timer select = 0 it is `timer_b`.
- R8: Outside mode 001, an interrupt-count field value n gives a one-cycle `irq` pulse on every (n+1)th stored capture.
- R9: Bit 3 reads 1 while at least one value is stored. `buf_rdata` shows the oldest value, and `buf_re` removes it.
- R10: Mode 000 empties the buffer and clears the overflow flag. Mode 110 stores nothing but keeps the values already held.
- R11: With idle stop = 1 and `idle` high, pin edges are ignored. With idle stop = 0, capturing continues while `idle` is high.
- R12: Mode 111 stores nothing. It pulses `irq` on a rising pin edge only while `sleep` or `idle` is high, and it ignores idle stop and all other fields.
- R13: Every control write restarts the edge prescaler and the interrupt counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | Asynchronous capture pin |
| timer_a | input | TW | Timer value chosen by timer select = 1 |
| timer_b | input | TW | Timer value chosen by timer select = 0 |
| idle | input | 1 | Device idle indication |
| sleep | input | 1 | Device sleep indication |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data |
| ctl_rdata | output | 16 | Control and status readback |
| buf_re | input | 1 | Pop the oldest stored value |
| buf_rdata | output | TW | Oldest stored value |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A pin change reaches storage three rising edges after it is driven: two synchroniser edges, then the storing edge. The interrupt pulse is high for exactly the cycle after that storing edge. The bench therefore drives the pin on a falling edge and waits four falling edges before it looks at status or interrupt counts. In the latency case it also checks that after only two edges nothing has been stored yet. Interrupt pulses are counted by a monitor that samples on falling edges. Pops and control writes take effect on the next rising edge, so their results are read one falling edge later.

// File: rtl/capture_channel.sv
module capture_channel #(
  parameter int TW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_in,
  input  logic [TW-1:0] timer_a,
  input  logic [TW-1:0] timer_b,
  input  logic          idle,
  input  logic          sleep,
  input  logic          ctl_we,
  input  logic [15:0]   ctl_wdata,
  output logic [15:0]   ctl_rdata,
  input  logic          buf_re,
  output logic [TW-1:0] buf_rdata,
  output logic          irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [2:0]    sync;
  logic          stop_idle, tsel, ovf;
  logic [1:0]    ici, icnt;
  logic [2:0]    mode;
  logic [3:0]    pre;
  logic [TW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          hit;

  wire rise    = sync[1] & ~sync[2];
  wire fall    = ~sync[1] & sync[2];
  wire run     = !(idle && stop_idle);
  wire pre_hit = (mode == 3'd4 && pre[1:0] == 2'd3) || (mode == 3'd5 && pre == 4'd15);
  wire cap     = run && hit;
  wire full    = (cnt == CW'(DEPTH));
  wire nempty  = (cnt != '0);
  wire pop     = buf_re && nempty;
  wire push    = cap && (!full || pop);

  always_comb begin
    case (mode)
      3'd1:        hit = rise | fall;
      3'd2:        hit = fall;
      3'd3:        hit = rise;
      3'd4, 3'd5:  hit = rise && pre_hit;
      default:     hit = 1'b0;
    endcase
  end

  assign ctl_rdata = {2'b00, stop_idle, 5'b00000, tsel, ici, ovf, nempty, mode};
  assign buf_rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync <= '0; stop_idle <= 1'b0; tsel <= 1'b0; ici <= '0; mode <= '0;
      ovf <= 1'b0; pre <= '0; icnt <= '0; wp <= '0; rp <= '0; cnt <= '0;
      irq <= 1'b0;
    end else begin
      sync <= {sync[1:0], pin_in};
      irq  <= 1'b0;

      if (ctl_we) begin
        stop_idle <= ctl_wdata[13];
        tsel      <= ctl_wdata[7];
        ici       <= ctl_wdata[6:5];
        mode      <= ctl_wdata[2:0];
        pre       <= '0;
        icnt      <= '0;
      end else begin
        if (run && rise && (mode == 3'd4 || mode == 3'd5))
          pre <= pre_hit ? 4'd0 : pre + 4'd1;
        if (push) begin
          if (mode == 3'd1 || icnt == ici) begin
            irq  <= 1'b1;
            icnt <= '0;
          end else begin
            icnt <= icnt + 2'd1;
          end
        end
      end

      if (mode == 3'd7)
        irq <= rise && (sleep || idle);

      if (mode == 3'd0) begin
        wp <= '0; rp <= '0; cnt <= '0; ovf <= 1'b0;
      end else begin
        if (push) begin
          mem[wp] <= tsel ? timer_a : timer_b;
          wp      <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
        end
        if (pop)
          rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(push) - CW'(pop);
        if (cap && full && !pop)
          ovf <= 1'b1;
      end
    end
  end
endmodule

module capture_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] ctl_rdata,
  input logic        buf_re,
  input logic        irq,
  input logic        sleep,
  input logic        idle
);
  assert_off_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[2:0] == 3'd0 |=> ctl_rdata[4:3] == 2'b00);

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[4] && ctl_rdata[2:0] != 3'd0) |=> ctl_rdata[4]);

  assert_wake_lowpower_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(ctl_rdata[2:0]) == 3'd7) |-> $past(sleep || idle));

  assert_empty_by_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_rdata[3]) |-> ($past(buf_re) || $past(ctl_rdata[2:0]) == 3'd0));

  assert_no_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[2:1] == 2'b11 && !ctl_rdata[3]) |=> !ctl_rdata[3]);
endmodule

bind capture_channel capture_channel_chk u_chk (.*);

// File: tb/tb_capture_channel.sv
module tb_capture_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, pin_in = 0, idle = 0, sleep = 0;
  logic [15:0] timer_a = 0, timer_b = 0, ctl_wdata = 0;
  logic        ctl_we = 0, buf_re = 0;
  logic [15:0] ctl_rdata, buf_rdata;
  logic        irq;
  int checks = 0, fails = 0, irqs = 0;

  capture_channel dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (irq) irqs++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic edge_to(input logic v);
    @(negedge clk); pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pop(input logic [15:0] exp, input string req);
    @(negedge clk);
    chk(buf_rdata == exp, req, buf_rdata, exp);
    buf_re = 1;
    @(negedge clk); buf_re = 0;
  endtask

  task automatic t_reset;
    chk(ctl_rdata == 16'h0, "R1", ctl_rdata, 0);
    chk(irq == 0, "R1", irq, 0);
  endtask

  task automatic t_readback;
    wr(16'hFFF4);
    chk(ctl_rdata == 16'h20E4, "R1", ctl_rdata, 16'h20E4);
    wr(16'h0000);
  endtask

  task automatic t_rising_latency;
    wr(16'h0083); timer_a = 16'hA111; timer_b = 16'hB222;
    @(negedge clk); pin_in = 1;
    repeat (2) @(negedge clk);
    chk(ctl_rdata[3] == 0, "R2", ctl_rdata[3], 0);
    @(negedge clk);
    chk(ctl_rdata[3] == 1, "R2", ctl_rdata[3], 1);
    repeat (2) @(negedge clk);
    pop(16'hA111, "R7");
    edge_to(0);
    chk(ctl_rdata[3] == 0, "R5", ctl_rdata[3], 0);
    wr(16'h0003); timer_b = 16'hB0B0;
    edge_to(1);
    pop(16'hB0B0, "R7");
    edge_to(0);
  endtask

  task automatic t_falling;
    wr(16'h0082); timer_a = 16'hF00D;
    edge_to(1);
    chk(ctl_rdata[3] == 0, "R5", ctl_rdata[3], 0);
    edge_to(0);
    chk(ctl_rdata[3] == 1, "R5", ctl_rdata[3], 1);
    pop(16'hF00D, "R5");
  endtask

  task automatic t_both_overflow;
    wr(16'h00E1); irqs = 0;
    for (int i = 0; i < 4; i++) begin
      timer_a = 16'h1000 + 16'(i);
      edge_to(i[0] ? 1'b0 : 1'b1);
    end
    chk(irqs == 4, "R4", irqs, 4);
    chk(ctl_rdata[4] == 0, "R3", ctl_rdata[4], 0);
    timer_a = 16'h1004;
    edge_to(1);
    chk(ctl_rdata[4] == 1, "R3", ctl_rdata[4], 1);
    for (int i = 0; i < 4; i++) pop(16'h1000 + 16'(i), "R3");
    chk(ctl_rdata[4:3] == 2'b10, "R9", ctl_rdata[4:3], 2);
    timer_a = 16'h1005;
    edge_to(0);
    wr(16'h0000);
    @(negedge clk);
    chk(ctl_rdata == 16'h0, "R10", ctl_rdata, 0);
  endtask

  task automatic t_count;
    wr(16'h00C3); irqs = 0;
    for (int i = 0; i < 6; i++) begin
      timer_a = 16'h3000 + 16'(i);
      edge_to(1);
      if (i == 1) chk(irqs == 0, "R8", irqs, 0);
      if (i == 2) chk(irqs == 1, "R8", irqs, 1);
      pop(16'h3000 + 16'(i), "R9");
      edge_to(0);
    end
    chk(irqs == 2, "R8", irqs, 2);
  endtask

  task automatic t_prescale;
    wr(16'h0084); timer_a = 16'h4444;
    for (int i = 0; i < 3; i++) begin edge_to(1); edge_to(0); end
    chk(ctl_rdata[3] == 0, "R6", ctl_rdata[3], 0);
    edge_to(1); edge_to(0);
    chk(ctl_rdata[3] == 1, "R6", ctl_rdata[3], 1);
    pop(16'h4444, "R6");
    wr(16'h0085); timer_a = 16'h5555;
    for (int i = 0; i < 15; i++) begin edge_to(1); edge_to(0); end
    chk(ctl_rdata[3] == 0, "R6", ctl_rdata[3], 0);
    edge_to(1); edge_to(0);
    pop(16'h5555, "R6");
  endtask

  task automatic t_write_restart;
    wr(16'h0084); timer_a = 16'h6161;
    for (int i = 0; i < 3; i++) begin edge_to(1); edge_to(0); end
    wr(16'h0084);
    edge_to(1); edge_to(0);
    chk(ctl_rdata[3] == 0, "R13", ctl_rdata[3], 0);
    for (int i = 0; i < 3; i++) begin edge_to(1); edge_to(0); end
    chk(ctl_rdata[3] == 1, "R13", ctl_rdata[3], 1);
    pop(16'h6161, "R13");
    wr(16'h00A3); irqs = 0;
    edge_to(1); edge_to(0); pop(16'h6161, "R13");
    wr(16'h00A3);
    edge_to(1); edge_to(0); pop(16'h6161, "R13");
    chk(irqs == 0, "R13", irqs, 0);
    edge_to(1); edge_to(0); pop(16'h6161, "R13");
    chk(irqs == 1, "R13", irqs, 1);
  endtask

  task automatic t_disabled;
    wr(16'h0083); timer_a = 16'h6666;
    edge_to(1); edge_to(0);
    wr(16'h0086); timer_a = 16'h7777;
    edge_to(1); edge_to(0);
    chk(ctl_rdata[3] == 1, "R10", ctl_rdata[3], 1);
    pop(16'h6666, "R10");
    chk(ctl_rdata[3] == 0, "R10", ctl_rdata[3], 0);
  endtask

  task automatic t_idle;
    wr(16'h2083); idle = 1; timer_a = 16'h8888;
    edge_to(1); edge_to(0);
    chk(ctl_rdata[3] == 0, "R11", ctl_rdata[3], 0);
    wr(16'h0083);
    edge_to(1); edge_to(0);
    chk(ctl_rdata[3] == 1, "R11", ctl_rdata[3], 1);
    pop(16'h8888, "R11");
    idle = 0;
  endtask

  task automatic t_wake;
    wr(16'h0007); irqs = 0;
    edge_to(1); edge_to(0);
    chk(irqs == 0, "R12", irqs, 0);
    sleep = 1;
    edge_to(1);
    chk(irqs == 1, "R12", irqs, 1);
    chk(ctl_rdata[3] == 0, "R12", ctl_rdata[3], 0);
    edge_to(0);
    chk(irqs == 1, "R12", irqs, 1);
    sleep = 0; idle = 1;
    wr(16'h2067);
    edge_to(1); edge_to(0);
    chk(irqs == 2, "R12", irqs, 2);
    idle = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_rising_latency();
    t_falling();
    t_both_overflow();
    t_count();
    t_prescale();
    t_write_restart();
    t_disabled();
    t_idle();
    t_wake();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule